// File: doc/BRIEF.md
# Retriggerable LED Pulse Stretcher

This block turns short or long status events into LED pulses that are long enough to see. A single event input is first passed through a two-flop synchronizer. A rising edge on the synchronized level then loads a countdown of millisecond ticks. The active-low LED output stays lit until that countdown reaches zero. If a new edge arrives while the countdown is running, the countdown is reloaded to its full value, so the pulse is extended.

When the countdown expires, the edge detector forgets the previous level. A level-type event that is still held high is therefore seen as a fresh edge. That edge reloads the countdown at once, so the LED stays lit for as long as the condition lasts, with no dark cycle at the expiry.

A 2-bit selector picks the stretch length: none, 30 ms, 60 ms or 100 ms. A prescaler derives the millisecond tick from the clock frequency parameter `CLK_HZ`. The block has no data stream; all of its pins are plain control and status signals.

Top module: `led_stretcher`

## Requirements
- R1: The selector `stretch_sel_i` uses this encoding: 2'b00 means no stretch, 2'b01 means 30 ms, 2'b10 means 60 ms and 2'b11 means 100 ms.
- R2: In no-stretch mode (2'b00), `led_n_o` equals the inverse of the event level seen through the two-flop synchronizer. It is low for exactly as many cycles as `evt_i` was high, and it follows `evt_i` two clock edges later.
- R3: In a stretch mode, an isolated event holds `led_n_o` low for exactly M*P+1 cycles, where M is the selected number of milliseconds and P = CLK_HZ/1000. The first low cycle is the one in which the synchronized rising edge is seen.
- R4: A new rising edge that arrives while a stretch is running reloads the full duration. Two events whose synchronized edges are D cycles apart, with D < M*P, give a single low run of D+M*P+1 cycles.
- R5: While `evt_i` stays high in a stretch mode, `led_n_o` stays low without a single high cycle, including across each countdown expiry.
- R6: The LED output is active low: 0 means lit and 1 means dark.
- R7: A synchronous active-high reset `rst` clears the synchronizer, the edge detector and the countdown. `led_n_o` is 1 in the cycle after reset, and it stays 1 until a new event arrives.
- R8: A change of the selector between two nonzero values does not alter a running stretch. The new duration applies from the next reload.
- R9: The millisecond tick lasts one cycle and comes every P cycles. Its prescaler restarts on every reload, so that each stretch is an exact number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Status event, asynchronous to clk, level or pulse |
| stretch_sel_i | input | 2 | Stretch selector: 00 none, 01 30 ms, 10 60 ms, 11 100 ms |
| led_n_o | output | 1 | LED drive, active low |

## Verification
The main function is driven with isolated pulses of several widths under each of the four selector values. These tell the bypass path, whose output length follows the input width, apart from the stretch path, whose output length is fixed by the selector. Two pulses closer together than one stretch show that the second one reloads the countdown rather than adding to it or being ignored. A held level running across several expiries shows that re-arming leaves no gap. A selector change during a stretch, and a reset during a stretch, show when a configuration takes effect and that a reset clears the stretch.

// File: rtl/led_str_pkg.sv
package led_str_pkg;

  typedef enum logic [1:0] {
    STR_NONE  = 2'b00,
    STR_SHORT = 2'b01,
    STR_MID   = 2'b10,
    STR_LONG  = 2'b11
  } stretch_mode_e;

  localparam int MS_SHORT = 30;
  localparam int MS_MID   = 60;
  localparam int MS_LONG  = 100;
  localparam int MS_MAX   = MS_LONG;

  // milliseconds for a selector value (R1)
  function automatic int sel_to_ms(input logic [1:0] sel);
    case (stretch_mode_e'(sel))
      STR_SHORT: return MS_SHORT;
      STR_MID:   return MS_MID;
      STR_LONG:  return MS_LONG;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/lstr_sync_edge.sv
module lstr_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  input  logic rearm_i,
  output logic level_o,
  output logic rise_o
);
  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      meta_q <= async_i;
      lvl_q  <= meta_q;
    end
  end

  // prev forgets on expiry so a held level looks new again (R5)
  always_ff @(posedge clk) begin
    if (rst || rearm_i) prev_q <= 1'b0;
    else                prev_q <= lvl_q;
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_q & ~prev_q;

  // R5: after a re-arm, a still-high level is reported as an edge
  p_rearm_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && meta_q) |=> rise_o);

endmodule

// File: rtl/lstr_ms_tick.sv
module lstr_ms_tick #(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRESCALE = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PRE_W    = $clog2(PRESCALE + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)    pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else                     pre_q <= pre_q + PRE_W'(1);
  end

  assign tick_o = (pre_q == PRE_LAST);

  generate
    if (PRESCALE > 1) begin : g_tick_chk
      // R9: tick is a single-cycle pulse
      p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
      // R9: a restart suppresses the tick in the following cycle
      p_tick_restart_r9: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/lstr_countdown.sv
module lstr_countdown #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable_i)           cnt_q <= '0;
    else if (load_i)                cnt_q <= dur_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = enable_i && !load_i && tick_i && (cnt_q == CNT_W'(1));

  // R4: a load sets the full selected duration
  p_reload_full_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && enable_i) |=> (cnt_q == $past(dur_i)));

  // R3: a running count only moves down, by one tick at a time
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !load_i && enable_i) |=>
      (!enable_i || load_i || cnt_q == $past(cnt_q) - CNT_W'($past(tick_i))));

  // R7: reset leaves the counter idle
  p_reset_idle_r7: assert property (@(posedge clk) rst |=> !busy_o);

endmodule

// File: rtl/led_stretcher.sv
module led_stretcher #(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_i,
  input  logic [1:0] stretch_sel_i,
  output logic       led_n_o
);
  import led_str_pkg::*;

  localparam int CNT_W = $clog2(MS_MAX + 1);

  logic             lvl, rise, rearm, tick, busy, load, stretching;
  logic [CNT_W-1:0] dur;

  assign stretching = (stretch_mode_e'(stretch_sel_i) != STR_NONE);
  assign load       = rise && stretching;
  assign dur        = CNT_W'(sel_to_ms(stretch_sel_i));

  lstr_sync_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (evt_i),
    .rearm_i (rearm),
    .level_o (lvl),
    .rise_o  (rise)
  );

  lstr_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .restart_i (load),
    .tick_o    (tick)
  );

  lstr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .enable_i (stretching),
    .load_i   (load),
    .dur_i    (dur),
    .tick_i   (tick),
    .busy_o   (busy),
    .expire_o (rearm)
  );

  // lit during the countdown and in the edge cycle that loads it (R3, R6)
  always_comb begin
    if (stretching) led_n_o = ~(busy | rise);
    else            led_n_o = ~lvl;
  end

  // R5: a held level never lets a lit LED go dark
  p_hold_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (stretching && $past(stretching) && !$past(led_n_o) && lvl && $past(lvl))
      |-> !led_n_o);

  // R7: dark in the cycle after reset
  p_reset_dark_r7: assert property (@(posedge clk) rst |=> led_n_o);

  // R3: a stretch can only start from a detected edge
  p_lit_from_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (stretching && $past(stretching) && $past(led_n_o) && !led_n_o) |-> rise);

endmodule

// File: tb/led_stretcher_bench.sv
module led_stretcher_bench;

  localparam int CLK_HZ = 4000;   // P = 4 cycles per ms
  localparam int P      = CLK_HZ / 1000;
  localparam int WIN    = 700;
  localparam int NVEC   = 7;

  // stimulus: selector, event-high cycles; expected LED low cycles (R1, R2, R3)
  localparam logic [1:0] V_SEL  [NVEC] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b10};
  localparam int         V_HOLD [NVEC] = '{5, 1, 1, 3, 2, 40, 1};
  localparam int         V_LOW  [NVEC] = '{5, 1, 30*P+1, 60*P+1, 100*P+1, 30*P+1, 60*P+1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       led_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  led_stretcher #(.CLK_HZ(CLK_HZ)) u_led_stretcher (
    .clk           (clk),
    .rst           (rst),
    .evt_i         (evt),
    .stretch_sel_i (sel),
    .led_n_o       (led_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive event high for hold cycles, count low samples and low runs over a window
  task automatic pulse_count(input int hold, output int lows, output int runs);
    logic last;
    lows = 0; runs = 0; last = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      evt = (i < hold);
      if (!led_n) lows++;
      if (last && !led_n) runs++;
      last = led_n;
    end
  endtask

  initial begin
    int lows, runs, highs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset dark", led_n, 1);
    check("R6 idle off is 1", led_n, 1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      sel = V_SEL[v];
      pulse_count(V_HOLD[v], lows, runs);
      check($sformatf("R1/R3 vec%0d low cycles", v), lows, V_LOW[v]);
      check($sformatf("R2 vec%0d single run", v), runs, 1);
    end

    // R2: bypass delay of two edges
    sel = 2'b00;
    @(negedge clk); evt = 1'b1;
    @(negedge clk); check("R2 not yet lit after 1 edge", led_n, 1);
    @(negedge clk); check("R2 lit after 2 edges", led_n, 0);
    evt = 1'b0;
    repeat (4) @(negedge clk);

    // R4: retrigger, edges 53 cycles apart
    sel = 2'b01;
    lows = 0; runs = 0;
    begin
      logic last;
      last = 1'b1;
      for (int i = 0; i < WIN; i++) begin
        @(negedge clk);
        evt = (i < 3) || (i >= 53 && i < 56);
        if (!led_n) lows++;
        if (last && !led_n) runs++;
        last = led_n;
      end
    end
    check("R4 retrigger low cycles", lows, 1 + 53 + 30*P);
    check("R4 retrigger single run", runs, 1);

    // R5: held level over several expiries
    sel = 2'b10;
    highs = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      evt = 1'b1;
      if (i >= 2 && led_n) highs++;
    end
    check("R5 held level high samples", highs, 0);
    evt = 1'b0;
    repeat (60*P + 10) @(negedge clk);
    check("R5 dark after release", led_n, 1);

    // R8: selector change mid-stretch applies at next reload
    sel = 2'b11;
    lows = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      evt = (i < 2);
      if (i == 20) sel = 2'b01;
      if (!led_n) lows++;
    end
    check("R8 running stretch unchanged", lows, 100*P + 1);
    pulse_count(2, lows, runs);
    check("R8 new selector at reload", lows, 30*P + 1);

    // R9: tick period seen through 1 ms granularity: 60 ms vs 30 ms differ by 30*P
    sel = 2'b10;
    pulse_count(1, lows, runs);
    check("R9 tick period", lows - (30*P + 1), 30*P);

    // R7: reset in mid-stretch clears it
    sel = 2'b11;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      evt = (i < 2);
    end
    check("R7 lit before reset", led_n, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 dark after reset", led_n, 1);
    highs = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (led_n) highs++;
    end
    check("R7 stays dark", highs, 50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule